// File: doc/BRIEF.md
# Transmit Descriptor Chain Walker

This block is the fetch side of a transmit DMA path. Software builds a linked chain of four-word transmit descriptors in memory. It marks each one as handed to the hardware and kicks the engine. The engine then reads each descriptor in turn over a simple one-word memory request port. It turns the buffer it describes, or every entry of an indirect fragment list, into address/length commands for a downstream byte mover. It then writes a completion status word back into the descriptor, and in that word the handoff flag is clear.

Each descriptor holds four words: status at offset 0, buffer pointer at offset 4, control at offset 8 and next pointer at offset 12. A frame may span several descriptors. The one flagged as last waits for the byte mover's completion report, which supplies the collision count and error flags for the written-back status. The engine raises a one-cycle interrupt pulse when a frame that asked for one has finished. It raises a one-cycle queue-empty pulse whenever it parks. It parks on reaching a descriptor it does not own, or on a null next pointer.

Top module: `txd_chain_fetch`

## Requirements
- R1: After reset no memory request, no command and no pulse is active. The first kick loads the descriptor pointer from `chain_head` with its low two bits cleared.
- R2: A descriptor is read in this order: status (+0), buffer pointer (+4), control (+8), next pointer (+12). Every memory address issued has bits 1:0 equal to zero.
- R3: If status bit 15 (owner) reads as 0, nothing else is read or written and `qempty` pulses. The next kick re-reads the same descriptor address and ignores `chain_head`.
- R4: With control bit 16 clear, one command is issued: address = buffer pointer as read, length = control[15:0], `cmd_nocrc` = control[19], `cmd_last` = control[20].
- R5: With control bit 16 set, the count word is read at the buffer pointer (aligned), followed by address/length pairs at +4/+8, +12/+16 and so on. One command is issued per pair with length = length word [15:0]. `cmd_last` is set only on the final pair, and only when control[20] is set.
- R6: A fragment count of 0 or greater than 16 issues no command and ends the frame. The status written back has bit 4 set and bit 0 clear.
- R7: For a descriptor with control[20] set, the write-back happens after `tx_done`. Its layout is: [31:16] = total frame bytes, [15] = 0, [12:8] = `tx_coll`, [6] = `tx_late`, [4] = `tx_underrun`, [0] = 1 only when neither error bit is set, and all other bits 0. It is written to the descriptor's +0 word.
- R8: A descriptor that does not end a frame is written back as soon as its commands are accepted. The value is the frame bytes so far in [31:16] and zero in [15:0].
- R9: `irq` pulses for one cycle after the write-back of a descriptor that ends a frame (last or aborted) and has control[18] set. It stays low otherwise.
- R10: A non-zero next pointer is followed without a kick. A zero next pointer parks the engine with a `qempty` pulse, and the next kick reloads from `chain_head`.
- R11: Reads use `mem_op` 2 (read-line) when `rd_cmd_sel[1]` is set, 1 (read-multiple) when only `rd_cmd_sel[0]` is set, and 0 (plain read) when both are clear. Writes use `mem_op` 3.
- R12: A memory request keeps its address, operation and write data until `mem_ack`. A command keeps its fields until `cmd_ready`. The two are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| kick | input | 1 | Queue kick, acted on only while parked |
| chain_head | input | 32 | Chain start address, loaded on a kick after end of chain |
| rd_cmd_sel | input | 2 | Read-command select for fetches |
| mem_req | output | 1 | Memory request active |
| mem_op | output | 2 | 0 read, 1 read-multiple, 2 read-line, 3 write |
| mem_addr | output | 32 | Word address (byte units, aligned) |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Byte mover accepts command |
| cmd_addr | output | 32 | Payload start address |
| cmd_len | output | 16 | Payload byte count |
| cmd_last | output | 1 | Final command of the frame |
| cmd_nocrc | output | 1 | Suppress CRC insertion for this frame |
| tx_done | input | 1 | Byte mover finished the frame |
| tx_coll | input | 5 | Collision count for the finished frame |
| tx_underrun | input | 1 | Underrun during the finished frame |
| tx_late | input | 1 | Out-of-window collision during the finished frame |
| irq | output | 1 | Frame-complete interrupt pulse |
| qempty | output | 1 | Engine parked pulse |

## Verification
On every cycle the checker covers the port contracts. These are word-aligned addresses, requests and commands that hold steady until accepted, no overlap between memory traffic and command issue, a cleared owner bit in every write, and the single-cycle width of both pulses. The directed scenarios cover what no single-cycle property can. These include the descriptor and fragment read order, the command fields derived from control bits, the packed status values for good, colliding, underrun and aborted frames, and the frame length summed across descriptors. They also cover interrupt gating, the choice between retrying the same descriptor and reloading the chain head, and the read-command encoding.

// File: rtl/txd_pkg.sv
// Shared types and field positions for the transmit descriptor chain walker.
// Assumes 32-bit descriptor words and 16-bit length fields.
package txd_pkg;
    localparam int WORD_W     = 32;
    localparam int LEN_W      = 16;
    localparam int COLL_W     = 5;
    localparam int OWN_BIT    = 15;
    localparam int CTL_LAST   = 20;
    localparam int CTL_NOCRC  = 19;
    localparam int CTL_IRQ    = 18;
    localparam int CTL_FRAG   = 16;
    localparam logic [WORD_W-1:0] ALIGN_MASK = 32'hFFFF_FFFC;

    typedef enum logic [3:0] {
        S_IDLE, S_RD_STAT, S_RD_BUF, S_RD_CTL, S_RD_NEXT,
        S_RD_FCNT, S_RD_FADDR, S_RD_FLEN, S_ISSUE, S_WAIT_DONE, S_WR_STAT
    } txd_state_e;

    typedef enum logic [1:0] {
        OP_RD      = 2'd0,
        OP_RD_MULT = 2'd1,
        OP_RD_LINE = 2'd2,
        OP_WR      = 2'd3
    } mem_op_e;
endpackage

// File: rtl/txd_rdop_dec.sv
// Maps the two-bit read-command select onto a memory read operation.
// Assumes line reads take precedence when both select bits are set.
module txd_rdop_dec
    import txd_pkg::*;
(
    input  logic [1:0] sel,
    output mem_op_e    op
);
    // Pick the read flavour from the select bits.
    always_comb begin
        if (sel[1])      op = OP_RD_LINE;
        else if (sel[0]) op = OP_RD_MULT;
        else             op = OP_RD;
    end
endmodule

// File: rtl/txd_wb_pack.sv
// Packs the completion status word written back into a descriptor.
// Assumes error fields are zero unless the descriptor ends a frame.
module txd_wb_pack
    import txd_pkg::*;
(
    input  logic [LEN_W-1:0]  frame_len,
    input  logic              frame_end,
    input  logic              abort,
    input  logic [COLL_W-1:0] coll,
    input  logic              late,
    input  logic              under,
    output logic [WORD_W-1:0] word
);
    logic       bad_dma;
    logic       sent_ok;

    // Build the status word from the frame totals and error flags.
    always_comb begin
        bad_dma = abort | under;
        sent_ok = ~(bad_dma | late);
        word    = {frame_len, 16'h0000};
        if (frame_end) begin
            word[12:8] = coll;
            word[6]    = late;
            word[4]    = bad_dma;
            word[0]    = sent_ok;
        end
    end
endmodule

// File: rtl/txd_req_mux.sv
// Drives the memory request port from the walker state and pointers.
// Assumes pointers arrive already word aligned.
module txd_req_mux
    import txd_pkg::*;
(
    input  txd_state_e        state,
    input  logic [WORD_W-1:0] desc_ptr,
    input  logic [WORD_W-1:0] frag_ptr,
    input  logic [WORD_W-1:0] wb_word,
    input  mem_op_e           rd_op,
    output logic              req,
    output logic [1:0]        op,
    output logic [WORD_W-1:0] addr,
    output logic [WORD_W-1:0] wdata
);
    // Select address, operation and data for the current state.
    always_comb begin
        req   = 1'b1;
        op    = rd_op;
        wdata = '0;
        addr  = desc_ptr;
        unique case (state)
            S_RD_STAT:  addr = desc_ptr;
            S_RD_BUF:   addr = desc_ptr + 32'd4;
            S_RD_CTL:   addr = desc_ptr + 32'd8;
            S_RD_NEXT:  addr = desc_ptr + 32'd12;
            S_RD_FCNT,
            S_RD_FADDR,
            S_RD_FLEN:  addr = frag_ptr;
            S_WR_STAT: begin
                op    = OP_WR;
                wdata = wb_word;
            end
            default:    req = 1'b0;
        endcase
    end
endmodule

// File: rtl/txd_chain_fetch.sv
// Walks a linked chain of transmit descriptors, issues payload commands
// and writes completion status back. One memory request is outstanding
// at a time; read data is valid in the cycle mem_ack is high.
module txd_chain_fetch
    import txd_pkg::*;
#(
    parameter int MAX_FRAGS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick,
    input  logic [31:0]       chain_head,
    input  logic [1:0]        rd_cmd_sel,
    output logic              mem_req,
    output logic [1:0]        mem_op,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [31:0]       cmd_addr,
    output logic [15:0]       cmd_len,
    output logic              cmd_last,
    output logic              cmd_nocrc,
    input  logic              tx_done,
    input  logic [4:0]        tx_coll,
    input  logic              tx_underrun,
    input  logic              tx_late,
    output logic              irq,
    output logic              qempty
);
    localparam int FCNT_W = $clog2(MAX_FRAGS + 1);
    localparam logic [WORD_W-1:0] MAX_CNT = WORD_W'(MAX_FRAGS);

    txd_state_e        state;
    logic              have_ptr;
    logic [WORD_W-1:0] desc_ptr, buf_ptr, next_ptr, frag_ptr;
    logic [LEN_W-1:0]  ctl_len;
    logic              ctl_last, ctl_nocrc, ctl_irq, ctl_frag;
    logic [FCNT_W-1:0] frag_left;
    logic [WORD_W-1:0] cmd_addr_q;
    logic [LEN_W-1:0]  cmd_len_q;
    logic              cmd_last_q;
    logic [LEN_W-1:0]  frame_len;
    logic              abort_q;
    logic [COLL_W-1:0] d_coll;
    logic              d_late, d_under;
    logic              irq_q, qempty_q;
    logic              frame_end;
    logic [WORD_W-1:0] wb_word;
    mem_op_e           rd_op;

    assign frame_end = ctl_last | abort_q;

    txd_rdop_dec u_dec (
        .sel (rd_cmd_sel),
        .op  (rd_op)
    );

    txd_wb_pack u_pack (
        .frame_len (frame_len),
        .frame_end (frame_end),
        .abort     (abort_q),
        .coll      (d_coll),
        .late      (d_late),
        .under     (d_under),
        .word      (wb_word)
    );

    txd_req_mux u_mux (
        .state    (state),
        .desc_ptr (desc_ptr),
        .frag_ptr (frag_ptr),
        .wb_word  (wb_word),
        .rd_op    (rd_op),
        .req      (mem_req),
        .op       (mem_op),
        .addr     (mem_addr),
        .wdata    (mem_wdata)
    );

    // Command stream outputs come straight from the held command registers.
    assign cmd_valid = (state == S_ISSUE);
    assign cmd_addr  = cmd_addr_q;
    assign cmd_len   = cmd_len_q;
    assign cmd_last  = cmd_last_q;
    assign cmd_nocrc = ctl_nocrc;
    assign irq       = irq_q;
    assign qempty    = qempty_q;

    // Main walker: fetch, issue, wait for completion, write back, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            have_ptr   <= 1'b0;
            desc_ptr   <= '0;
            buf_ptr    <= '0;
            next_ptr   <= '0;
            frag_ptr   <= '0;
            ctl_len    <= '0;
            ctl_last   <= 1'b0;
            ctl_nocrc  <= 1'b0;
            ctl_irq    <= 1'b0;
            ctl_frag   <= 1'b0;
            frag_left  <= '0;
            cmd_addr_q <= '0;
            cmd_len_q  <= '0;
            cmd_last_q <= 1'b0;
            frame_len  <= '0;
            abort_q    <= 1'b0;
            d_coll     <= '0;
            d_late     <= 1'b0;
            d_under    <= 1'b0;
            irq_q      <= 1'b0;
            qempty_q   <= 1'b0;
        end else begin
            irq_q    <= 1'b0;
            qempty_q <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (kick) begin
                        if (!have_ptr) begin
                            desc_ptr <= chain_head & ALIGN_MASK;
                            have_ptr <= 1'b1;
                        end
                        state <= S_RD_STAT;
                    end
                end
                S_RD_STAT: begin
                    if (mem_ack) begin
                        if (!mem_rdata[OWN_BIT]) begin
                            qempty_q <= 1'b1;
                            state    <= S_IDLE;
                        end else begin
                            state <= S_RD_BUF;
                        end
                    end
                end
                S_RD_BUF: begin
                    if (mem_ack) begin
                        buf_ptr <= mem_rdata;
                        state   <= S_RD_CTL;
                    end
                end
                S_RD_CTL: begin
                    if (mem_ack) begin
                        ctl_len   <= mem_rdata[LEN_W-1:0];
                        ctl_last  <= mem_rdata[CTL_LAST];
                        ctl_nocrc <= mem_rdata[CTL_NOCRC];
                        ctl_irq   <= mem_rdata[CTL_IRQ];
                        ctl_frag  <= mem_rdata[CTL_FRAG];
                        state     <= S_RD_NEXT;
                    end
                end
                S_RD_NEXT: begin
                    if (mem_ack) begin
                        next_ptr <= mem_rdata & ALIGN_MASK;
                        if (ctl_frag) begin
                            frag_ptr <= buf_ptr & ALIGN_MASK;
                            state    <= S_RD_FCNT;
                        end else begin
                            cmd_addr_q <= buf_ptr;
                            cmd_len_q  <= ctl_len;
                            cmd_last_q <= ctl_last;
                            state      <= S_ISSUE;
                        end
                    end
                end
                S_RD_FCNT: begin
                    if (mem_ack) begin
                        if (mem_rdata == '0 || mem_rdata > MAX_CNT) begin
                            abort_q <= 1'b1;
                            state   <= S_WR_STAT;
                        end else begin
                            frag_left <= mem_rdata[FCNT_W-1:0];
                            frag_ptr  <= frag_ptr + 32'd4;
                            state     <= S_RD_FADDR;
                        end
                    end
                end
                S_RD_FADDR: begin
                    if (mem_ack) begin
                        cmd_addr_q <= mem_rdata;
                        frag_ptr   <= frag_ptr + 32'd4;
                        state      <= S_RD_FLEN;
                    end
                end
                S_RD_FLEN: begin
                    if (mem_ack) begin
                        cmd_len_q  <= mem_rdata[LEN_W-1:0];
                        cmd_last_q <= ctl_last && (frag_left == FCNT_W'(1));
                        frag_left  <= frag_left - FCNT_W'(1);
                        frag_ptr   <= frag_ptr + 32'd4;
                        state      <= S_ISSUE;
                    end
                end
                S_ISSUE: begin
                    if (cmd_ready) begin
                        frame_len <= frame_len + cmd_len_q;
                        if (ctl_frag && frag_left != '0) state <= S_RD_FADDR;
                        else if (ctl_last)                state <= S_WAIT_DONE;
                        else                              state <= S_WR_STAT;
                    end
                end
                S_WAIT_DONE: begin
                    if (tx_done) begin
                        d_coll  <= tx_coll;
                        d_late  <= tx_late;
                        d_under <= tx_underrun;
                        state   <= S_WR_STAT;
                    end
                end
                S_WR_STAT: begin
                    if (mem_ack) begin
                        irq_q <= frame_end & ctl_irq;
                        if (frame_end) begin
                            frame_len <= '0;
                            abort_q   <= 1'b0;
                            d_coll    <= '0;
                            d_late    <= 1'b0;
                            d_under   <= 1'b0;
                        end
                        if (next_ptr == '0) begin
                            qempty_q <= 1'b1;
                            have_ptr <= 1'b0;
                            state    <= S_IDLE;
                        end else begin
                            desc_ptr <= next_ptr;
                            state    <= S_RD_STAT;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/txd_chain_fetch_chk.sv
// Port-level protocol checker for the descriptor chain walker.
// Assumes it is bound to txd_chain_fetch with matching port names.
module txd_chain_fetch_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic [1:0]  mem_op,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ack,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic [31:0] cmd_addr,
    input logic [15:0] cmd_len,
    input logic        cmd_last,
    input logic        irq,
    input logic        qempty
);
    // R2
    aligned_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_op) && $stable(mem_wdata)));

    // R12
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) &&
                                       $stable(cmd_len) && $stable(cmd_last)));

    // R12
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && cmd_valid));

    // R7
    owner_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_op == 2'b11) |-> !mem_wdata[15]);

    // R9
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R3
    qempty_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        qempty |-> (!mem_req && !cmd_valid));

    // R10
    qempty_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        qempty |=> !qempty);
endmodule

bind txd_chain_fetch txd_chain_fetch_chk u_chk (.*);

// File: tb/tb_txd_chain_fetch.sv
// Directed bench for the descriptor chain walker with a word memory model,
// a command sink and a completion responder.
module tb_txd_chain_fetch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        kick = 1'b0;
    logic [31:0] chain_head = '0;
    logic [1:0]  rd_cmd_sel = 2'b00;
    logic        mem_req;
    logic [1:0]  mem_op;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b1;
    logic [31:0] cmd_addr;
    logic [15:0] cmd_len;
    logic        cmd_last, cmd_nocrc;
    logic        tx_done = 1'b0;
    logic [4:0]  tx_coll = '0;
    logic        tx_underrun = 1'b0;
    logic        tx_late = 1'b0;
    logic        irq, qempty;

    int checks = 0;
    int errors = 0;

    logic [31:0] mem [0:255];
    logic [31:0] r_addr [0:63];
    logic [1:0]  r_op   [0:63];
    logic [31:0] w_addr [0:63];
    logic [31:0] w_data [0:63];
    logic [31:0] c_addr [0:63];
    logic [15:0] c_len  [0:63];
    logic        c_last [0:63];
    logic        c_nocrc[0:63];
    int rn = 0, wn = 0, cn = 0, irq_cnt = 0, qe_cnt = 0;
    int done_timer = 0;
    logic [4:0] done_coll = '0;
    logic done_late = 1'b0, done_under = 1'b0;
    logic bp_en = 1'b0;

    always #4 clk = ~clk;

    txd_chain_fetch dut (
        .clk(clk), .rst_n(rst_n), .kick(kick), .chain_head(chain_head),
        .rd_cmd_sel(rd_cmd_sel), .mem_req(mem_req), .mem_op(mem_op),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_last(cmd_last),
        .cmd_nocrc(cmd_nocrc), .tx_done(tx_done), .tx_coll(tx_coll),
        .tx_underrun(tx_underrun), .tx_late(tx_late), .irq(irq), .qempty(qempty)
    );

    // Memory model: acknowledges every other cycle and logs each access.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) mem_rdata <= mem[mem_addr[9:2]];
            if (mem_req && mem_ack) begin
                if (mem_op == 2'b11) begin
                    mem[mem_addr[9:2]] = mem_wdata;
                    if (wn < 64) begin w_addr[wn] = mem_addr; w_data[wn] = mem_wdata; end
                    wn++;
                end else begin
                    if (rn < 64) begin r_addr[rn] = mem_addr; r_op[rn] = mem_op; end
                    rn++;
                end
            end
        end
    end

    // Command sink, completion responder and pulse counters.
    always @(posedge clk) begin
        tx_done <= 1'b0;
        cmd_ready <= bp_en ? ~cmd_ready : 1'b1;
        if (rst_n) begin
            if (irq) irq_cnt++;
            if (qempty) qe_cnt++;
            if (cmd_valid && cmd_ready) begin
                if (cn < 64) begin
                    c_addr[cn] = cmd_addr; c_len[cn] = cmd_len;
                    c_last[cn] = cmd_last; c_nocrc[cn] = cmd_nocrc;
                end
                cn++;
                if (cmd_last) done_timer = 4;
            end
            if (done_timer != 0) begin
                done_timer--;
                if (done_timer == 0) begin
                    tx_done     <= 1'b1;
                    tx_coll     <= done_coll;
                    tx_late     <= done_late;
                    tx_underrun <= done_under;
                end
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic clear_logs();
        rn = 0; wn = 0; cn = 0; irq_cnt = 0; qe_cnt = 0;
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] st,
                            input logic [31:0] bp, input logic [31:0] ctl,
                            input logic [31:0] nx);
        mem[a[9:2]]     = st;
        mem[a[9:2] + 1] = bp;
        mem[a[9:2] + 2] = ctl;
        mem[a[9:2] + 3] = nx;
    endtask

    function automatic logic [31:0] mk_ctl(input logic [15:0] len, input bit last,
                                           input bit nocrc, input bit iaf, input bit frag);
        return {11'd0, last, nocrc, iaf, 1'b0, frag, len};
    endfunction

    task automatic do_kick(input logic [31:0] head);
        @(negedge clk);
        chain_head = head;
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
    endtask

    task automatic wait_park();
        int start;
        start = qe_cnt;
        while (qe_cnt == start) @(posedge clk);
        repeat (3) @(negedge clk);
    endtask

    // R1: reset state of every output that can act.
    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1", "mem_req in reset", {31'd0, mem_req}, 32'd0);
        chk("R1", "cmd_valid in reset", {31'd0, cmd_valid}, 32'd0);
        chk("R1", "irq/qempty in reset", {30'd0, irq, qempty}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "mem_req idle after reset", {31'd0, mem_req}, 32'd0);
    endtask

    // R1 R2 R4 R7 R9 R11: single direct descriptor, plain reads.
    task automatic t_single();
        clear_logs();
        rd_cmd_sel = 2'b00;
        done_coll = 0; done_late = 0; done_under = 0;
        put_desc(32'h040, 32'h0000_8000, 32'h0000_5000, mk_ctl(16'h003C, 1, 0, 1, 0), 32'h0);
        do_kick(32'h042);
        wait_park();
        chk("R2", "read count", rn, 4);
        chk("R1", "first read at aligned head", r_addr[0], 32'h040);
        chk("R2", "read +4", r_addr[1], 32'h044);
        chk("R2", "read +8", r_addr[2], 32'h048);
        chk("R2", "read +12", r_addr[3], 32'h04C);
        chk("R11", "plain read op", {30'd0, r_op[0]}, 32'd0);
        chk("R4", "cmd count", cn, 1);
        chk("R4", "cmd addr", c_addr[0], 32'h5000);
        chk("R4", "cmd len", {16'd0, c_len[0]}, 32'h3C);
        chk("R4", "cmd last/nocrc", {30'd0, c_last[0], c_nocrc[0]}, 32'd2);
        chk("R7", "writeback addr", w_addr[0], 32'h040);
        chk("R7", "writeback good", w_data[0], 32'h003C_0001);
        chk("R9", "irq count", irq_cnt, 1);
    endtask

    // R8 R7 R10 R11 R4: two-descriptor frame, read-multiple, collisions.
    task automatic t_chain();
        clear_logs();
        rd_cmd_sel = 2'b01;
        done_coll = 5'd5; done_late = 1; done_under = 0;
        put_desc(32'h080, 32'h0000_8000, 32'h0000_6001, mk_ctl(16'h0020, 0, 1, 0, 0), 32'h0A0);
        put_desc(32'h0A0, 32'h0000_8000, 32'h0000_7000, mk_ctl(16'h0030, 1, 0, 0, 0), 32'h0);
        do_kick(32'h080);
        wait_park();
        chk("R10", "followed chain without kick: reads", rn, 8);
        chk("R11", "read-multiple op", {30'd0, r_op[5]}, 32'd1);
        chk("R4", "cmd count", cn, 2);
        chk("R4", "unaligned buffer passed raw", c_addr[0], 32'h6001);
        chk("R4", "first cmd last/nocrc", {30'd0, c_last[0], c_nocrc[0]}, 32'd1);
        chk("R4", "second cmd last/nocrc", {30'd0, c_last[1], c_nocrc[1]}, 32'd2);
        chk("R8", "non-last writeback", w_data[0], 32'h0020_0000);
        chk("R7", "last writeback addr", w_addr[1], 32'h0A0);
        chk("R7", "last writeback coll/late", w_data[1], 32'h0050_0540);
        chk("R9", "no irq without request", irq_cnt, 0);
    endtask

    // R5 R7 R11 R12 R10: fragment list of three, read-line, backpressure.
    task automatic t_frags();
        clear_logs();
        rd_cmd_sel = 2'b11;
        bp_en = 1'b1;
        done_coll = 0; done_late = 0; done_under = 1;
        put_desc(32'h0C0, 32'h0000_8000, 32'h0000_0200, mk_ctl(16'h1234, 1, 0, 1, 1), 32'h0);
        mem[8'h80] = 32'd3;
        mem[8'h81] = 32'h1000; mem[8'h82] = 32'd10;
        mem[8'h83] = 32'h2000; mem[8'h84] = 32'd20;
        mem[8'h85] = 32'h3000; mem[8'h86] = 32'd30;
        do_kick(32'h0C0);
        wait_park();
        bp_en = 1'b0;
        chk("R10", "reload from head after null", r_addr[0], 32'h0C0);
        chk("R5", "read count", rn, 11);
        chk("R5", "count word addr", r_addr[4], 32'h200);
        chk("R5", "last length addr", r_addr[10], 32'h218);
        chk("R11", "read-line op", {30'd0, r_op[6]}, 32'd2);
        chk("R5", "cmd count", cn, 3);
        chk("R5", "frag2 addr/len", {c_addr[1][15:0], c_len[1]}, 32'h2000_0014);
        chk("R12", "frag3 len under backpressure", {16'd0, c_len[2]}, 32'd30);
        chk("R5", "last flags", {29'd0, c_last[0], c_last[1], c_last[2]}, 32'd1);
        chk("R7", "underrun writeback", w_data[0], 32'h003C_0010);
        chk("R9", "irq on frag frame", irq_cnt, 1);
    endtask

    // R6 R9: fragment counts of zero and seventeen abort their frames.
    task automatic t_abort();
        clear_logs();
        rd_cmd_sel = 2'b10;
        put_desc(32'h100, 32'h0000_8000, 32'h0000_0240, mk_ctl(16'h0, 0, 0, 1, 1), 32'h110);
        put_desc(32'h110, 32'h0000_8000, 32'h0000_0260, mk_ctl(16'h0, 1, 0, 1, 1), 32'h0);
        mem[8'h90] = 32'd0;
        mem[8'h98] = 32'd17;
        do_kick(32'h100);
        wait_park();
        chk("R6", "no commands", cn, 0);
        chk("R6", "two writebacks", wn, 2);
        chk("R6", "zero count status", w_data[0], 32'h0000_0010);
        chk("R6", "count 17 status", w_data[1], 32'h0000_0010);
        chk("R9", "irq per aborted frame", irq_cnt, 2);
    endtask

    // R3: unowned descriptor parks; kick retries the same address.
    task automatic t_unowned();
        clear_logs();
        rd_cmd_sel = 2'b00;
        done_coll = 0; done_late = 0; done_under = 0;
        put_desc(32'h300, 32'h0, 32'h0000_9000, mk_ctl(16'h0008, 1, 0, 0, 0), 32'h0);
        do_kick(32'h300);
        wait_park();
        chk("R3", "only status read", rn, 1);
        chk("R3", "no write", wn, 0);
        chk("R3", "no command", cn, 0);
        chk("R3", "qempty pulse", qe_cnt, 1);
        clear_logs();
        mem[8'hC0] = 32'h0000_8000;
        do_kick(32'h000);
        wait_park();
        chk("R3", "retry same descriptor", r_addr[0], 32'h300);
        chk("R3", "retry writeback addr", w_addr[0], 32'h300);
        chk("R3", "retry writeback data", w_data[0], 32'h0008_0001);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog: actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        t_reset();
        t_single();
        t_chain();
        t_frags();
        t_abort();
        t_unowned();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule